// File: doc/BRIEF.md
# BCD Real-Time Calendar Register Bank

This block keeps wall-clock time and a calendar date, advanced by a one-pulse-per-second tick from elsewhere on the chip. It holds seconds, minutes, hours, a day-of-week counter, day of month, month and a two-digit year. A host reads and presets these fields through an eight-location, byte-wide register window that is selected by a 3-bit offset.

The host sees mixed encodings. Time-of-day fields, the day of month and the year appear as packed BCD. The weekday and the month appear as plain binary. The top location is a status byte that always reads zero, which tells the host that the data registers can be read. Internally every field is a binary counter. Encoding is applied only at the read and write edges, so the rollover chain compares against plain binary limits.

Top module: `bcd_calendar_regs`

## Requirements
- R1: Offsets 0 to 6 select, in that order, seconds, minutes, hours, weekday, day of month, month and year. The same offset is used for reads and for writes.
- R2: Seconds, minutes, hours, day of month and year read as packed BCD (tens digit in bits 7:4, units digit in bits 3:0). A write to any of these offsets takes its data in the same packed BCD form.
- R3: The weekday reads as a binary value in bits 2:0, with bits 7:3 zero. It counts 0 to 6, wraps to 0, and advances whenever the hours wrap. A write loads it from data bits 2:0.
- R4: The month reads as binary 1 to 12 in bits 3:0, with bits 7:4 zero. It wraps from 12 to 1 and that wrap advances the year. A write loads it from data bits 3:0.
- R5: The year holds two decimal digits and wraps from 99 to 00.
- R6: Offset 7 reads as 0x00, so bit 0 is clear. A write to offset 7 changes no field. While the read strobe is low, the read data is 0x00.
- R7: Each tick advances seconds. The chain then carries as follows: seconds wrap 59 to 00 and advance minutes, minutes wrap 59 to 00 and advance hours, and hours wrap 23 to 00 and advance both day and weekday. A field at or above its limit wraps on its next increment. Without a tick or a write, no field changes.
- R8: The day of month wraps to 1 after the last day of the current month. That last day is 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for months 4, 6, 9 and 11. For month 2 it is 29 when the year is divisible by 4, and 28 otherwise. The wrap advances the month.
- R9: A write loads the addressed field at the next clock edge. It wins over an increment that arrives in the same cycle. The displaced increment produces no carry into the next field.
- R10: Reset (active-low, asynchronous) sets the time to 00:00:00, weekday 0, day 1, month 1 and year 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe; loads the addressed field at the clock edge |
| bus_rd | input | 1 | Read strobe; enables the read data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset (combinational) |

## Verification
The assertions check the following on every cycle:
- the status byte and the idle read bus stay at zero;
- seconds, minutes and hours hold still without a tick or a write;
- a seconds wrap lands on zero and moves minutes forward by one;
- a month wrap lands on 1;
- a seconds write is taken over a simultaneous tick.

Some behaviours can only be shown by the bench's scenarios against its behavioural model. These are the month-length and leap-year limits on the day of month, the full midnight carry from December 31 of year 99 into the new year, and the weekday wrap. They also include the exact BCD and binary formatting of every offset, and the fact that a displaced increment carries nothing onward.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int FIELD_W   = 7;
  localparam int NUM_FIELD = 7;
  localparam int BYTE_W    = 8;
  localparam int OFF_W     = 3;

  localparam logic [OFF_W-1:0] OFF_SEC  = 3'd0;
  localparam logic [OFF_W-1:0] OFF_MIN  = 3'd1;
  localparam logic [OFF_W-1:0] OFF_HOUR = 3'd2;
  localparam logic [OFF_W-1:0] OFF_WDAY = 3'd3;
  localparam logic [OFF_W-1:0] OFF_DAY  = 3'd4;
  localparam logic [OFF_W-1:0] OFF_MON  = 3'd5;
  localparam logic [OFF_W-1:0] OFF_YEAR = 3'd6;
  localparam logic [OFF_W-1:0] OFF_STAT = 3'd7;

  // packed BCD byte -> binary
  function automatic logic [FIELD_W-1:0] bcd_to_bin(input logic [BYTE_W-1:0] b);
    logic [FIELD_W-1:0] tens;
    logic [FIELD_W-1:0] units;
    tens  = FIELD_W'(b[7:4]);
    units = FIELD_W'(b[3:0]);
    return FIELD_W'(tens * FIELD_W'(10) + units);
  endfunction

  // binary (0..99) -> packed BCD byte
  function automatic logic [BYTE_W-1:0] bin_to_bcd(input logic [FIELD_W-1:0] v);
    logic [FIELD_W-1:0] tens;
    logic [FIELD_W-1:0] units;
    tens  = v / FIELD_W'(10);
    units = v % FIELD_W'(10);
    return {tens[3:0], units[3:0]};
  endfunction

  // last day of a month, leap February when year divisible by 4
  function automatic logic [FIELD_W-1:0] month_last_day(input logic [FIELD_W-1:0] mon,
                                                        input logic [FIELD_W-1:0] yr);
    logic [FIELD_W-1:0] d;
    case (mon)
      7'd2:                      d = (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   d = 7'd30;
      default:                   d = 7'd31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cal_field.sv
module cal_field #(
  parameter int W = 7,
  parameter logic [W-1:0] MIN_V = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_v,
  input  logic [W-1:0] max_v,
  output logic [W-1:0] value_q,
  output logic         wrap
);

  logic at_limit;

  assign at_limit = (value_q >= max_v);
  // carry onward only when the increment is really taken
  assign wrap     = inc & at_limit & ~load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= MIN_V;
    end else if (load) begin
      value_q <= load_v;
    end else if (inc) begin
      value_q <= at_limit ? MIN_V : value_q + W'(1);
    end
  end

endmodule

// File: rtl/cal_read_mux.sv
module cal_read_mux
  import cal_pkg::*;
(
  input  logic                 rd,
  input  logic [OFF_W-1:0]     addr,
  input  logic [FIELD_W-1:0]   sec_v,
  input  logic [FIELD_W-1:0]   min_v,
  input  logic [FIELD_W-1:0]   hour_v,
  input  logic [FIELD_W-1:0]   wday_v,
  input  logic [FIELD_W-1:0]   day_v,
  input  logic [FIELD_W-1:0]   mon_v,
  input  logic [FIELD_W-1:0]   year_v,
  output logic [BYTE_W-1:0]    rdata
);

  logic [BYTE_W-1:0] sel;

  always_comb begin
    case (addr)
      OFF_SEC:  sel = bin_to_bcd(sec_v);
      OFF_MIN:  sel = bin_to_bcd(min_v);
      OFF_HOUR: sel = bin_to_bcd(hour_v);
      OFF_WDAY: sel = {5'b0, wday_v[2:0]};
      OFF_DAY:  sel = bin_to_bcd(day_v);
      OFF_MON:  sel = {4'b0, mon_v[3:0]};
      OFF_YEAR: sel = bin_to_bcd(year_v);
      default:  sel = '0;
    endcase
    rdata = rd ? sel : '0;
  end

endmodule

// File: rtl/bcd_calendar_regs.sv
module bcd_calendar_regs
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic [OFF_W-1:0]  bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata
);

  localparam int NSEL = 1 << OFF_W;

  logic [NSEL-1:0]    wr_sel;
  logic [FIELD_W-1:0] fld_q    [NUM_FIELD];
  logic [FIELD_W-1:0] fld_max  [NUM_FIELD];
  logic [FIELD_W-1:0] fld_ldv  [NUM_FIELD];
  logic [NUM_FIELD-1:0] fld_inc;
  logic [NUM_FIELD-1:0] fld_wrap;

  logic [FIELD_W-1:0] wr_bcd_bin;

  // named internal events for the checker
  logic [FIELD_W-1:0] sec_q, min_q, hour_q, wday_q, day_q, mon_q, year_q;
  logic sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap;

  assign wr_sel     = bus_wr ? (NSEL'(1) << bus_addr) : '0;
  assign wr_bcd_bin = bcd_to_bin(bus_wdata);

  assign sec_q  = fld_q[OFF_SEC];
  assign min_q  = fld_q[OFF_MIN];
  assign hour_q = fld_q[OFF_HOUR];
  assign wday_q = fld_q[OFF_WDAY];
  assign day_q  = fld_q[OFF_DAY];
  assign mon_q  = fld_q[OFF_MON];
  assign year_q = fld_q[OFF_YEAR];

  assign sec_wrap  = fld_wrap[OFF_SEC];
  assign min_wrap  = fld_wrap[OFF_MIN];
  assign hour_wrap = fld_wrap[OFF_HOUR];
  assign day_wrap  = fld_wrap[OFF_DAY];
  assign mon_wrap  = fld_wrap[OFF_MON];

  // carry chain: hours feed both the day of month and the weekday
  assign fld_inc[OFF_SEC]  = tick_1hz;
  assign fld_inc[OFF_MIN]  = sec_wrap;
  assign fld_inc[OFF_HOUR] = min_wrap;
  assign fld_inc[OFF_WDAY] = hour_wrap;
  assign fld_inc[OFF_DAY]  = hour_wrap;
  assign fld_inc[OFF_MON]  = day_wrap;
  assign fld_inc[OFF_YEAR] = mon_wrap;

  assign fld_max[OFF_SEC]  = 7'd59;
  assign fld_max[OFF_MIN]  = 7'd59;
  assign fld_max[OFF_HOUR] = 7'd23;
  assign fld_max[OFF_WDAY] = 7'd6;
  assign fld_max[OFF_DAY]  = month_last_day(mon_q, year_q);
  assign fld_max[OFF_MON]  = 7'd12;
  assign fld_max[OFF_YEAR] = 7'd99;

  assign fld_ldv[OFF_SEC]  = wr_bcd_bin;
  assign fld_ldv[OFF_MIN]  = wr_bcd_bin;
  assign fld_ldv[OFF_HOUR] = wr_bcd_bin;
  assign fld_ldv[OFF_WDAY] = {4'b0, bus_wdata[2:0]};
  assign fld_ldv[OFF_DAY]  = wr_bcd_bin;
  assign fld_ldv[OFF_MON]  = {3'b0, bus_wdata[3:0]};
  assign fld_ldv[OFF_YEAR] = wr_bcd_bin;

  for (genvar i = 0; i < NUM_FIELD; i++) begin : g_field
    localparam logic [FIELD_W-1:0] FMIN =
      (i == int'(OFF_DAY) || i == int'(OFF_MON)) ? FIELD_W'(1) : FIELD_W'(0);
    cal_field #(.W(FIELD_W), .MIN_V(FMIN)) u_fld (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (fld_inc[i]),
      .load    (wr_sel[i]),
      .load_v  (fld_ldv[i]),
      .max_v   (fld_max[i]),
      .value_q (fld_q[i]),
      .wrap    (fld_wrap[i])
    );
  end

  cal_read_mux u_rmux (
    .rd     (bus_rd),
    .addr   (bus_addr),
    .sec_v  (sec_q),
    .min_v  (min_q),
    .hour_v (hour_q),
    .wday_v (wday_q),
    .day_v  (day_q),
    .mon_v  (mon_q),
    .year_v (year_q),
    .rdata  (bus_rdata)
  );

endmodule

// File: rtl/cal_regs_checker.sv
module cal_regs_checker
  import cal_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick_1hz,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [OFF_W-1:0]  bus_addr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic [FIELD_W-1:0] sec_q,
  input logic [FIELD_W-1:0] min_q,
  input logic [FIELD_W-1:0] hour_q,
  input logic [FIELD_W-1:0] mon_q,
  input logic              sec_wrap,
  input logic              mon_wrap
);

  logic [FIELD_W-1:0] wr_val;
  logic               min_written;
  logic               mon_written;
  assign wr_val      = bcd_to_bin(bus_wdata);
  assign min_written = bus_wr && (bus_addr == OFF_MIN);
  assign mon_written = bus_wr && (bus_addr == OFF_MON);

  assert_status_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFF_STAT) |-> (bus_rdata == 8'h00));

  assert_rd_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'h00));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz && !bus_wr) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q)));

  assert_sec_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wrap |=> (sec_q == 7'd0));

  assert_min_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_wrap && !min_written && min_q < 7'd59) |=> (min_q == $past(min_q) + 7'd1));

  assert_month_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_wrap && !mon_written) |=> (mon_q == 7'd1));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_SEC) |=> (sec_q == $past(wr_val)));

endmodule

bind bcd_calendar_regs cal_regs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_1hz  (tick_1hz),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .sec_q     (sec_q),
  .min_q     (min_q),
  .hour_q    (hour_q),
  .mon_q     (mon_q),
  .sec_wrap  (sec_wrap),
  .mon_wrap  (mon_wrap)
);

// File: tb/sim_bcd_calendar_regs.sv
`timescale 1ns/1ps
module sim_bcd_calendar_regs;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_calendar_regs u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // behavioural reference state
  int m_f[7];

  function automatic int days_of(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic int to_bcd(int v);
    return (v / 10) * 16 + (v % 10);
  endfunction

  function automatic int from_bcd(int d);
    return ((d / 16) % 16) * 10 + (d % 16);
  endfunction

  function automatic int model_read(int a);
    case (a)
      3: return m_f[3];
      5: return m_f[5];
      7: return 0;
      default: return to_bcd(m_f[a]);
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      3: return "R3";
      4: return "R8";
      5: return "R4";
      6: return "R5";
      7: return "R6";
      default: return "R2";
    endcase
  endfunction

  // model steps on the clock: increments from old values, then writes
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_f[0] = 0; m_f[1] = 0; m_f[2] = 0; m_f[3] = 0;
      m_f[4] = 1; m_f[5] = 1; m_f[6] = 0;
    end else begin
      int lim;
      int carry;
      int w;
      w = bus_wr ? int'(bus_addr) : -1;
      lim = days_of(m_f[5], m_f[6]);
      carry = 0;
      if (tick_1hz && w != 0) begin
        if (m_f[0] >= 59) begin m_f[0] = 0; carry = 1; end else m_f[0] = m_f[0] + 1;
      end
      if (carry == 1) begin
        carry = 0;
        if (w != 1) begin
          if (m_f[1] >= 59) begin m_f[1] = 0; carry = 1; end else m_f[1] = m_f[1] + 1;
        end
      end
      if (carry == 1) begin
        carry = 0;
        if (w != 2) begin
          if (m_f[2] >= 23) begin m_f[2] = 0; carry = 1; end else m_f[2] = m_f[2] + 1;
        end
      end
      if (carry == 1) begin
        carry = 0;
        if (w != 3) m_f[3] = (m_f[3] >= 6) ? 0 : m_f[3] + 1;
        if (w != 4) begin
          if (m_f[4] >= lim) begin m_f[4] = 1; carry = 1; end else m_f[4] = m_f[4] + 1;
        end
      end
      if (carry == 1) begin
        carry = 0;
        if (w != 5) begin
          if (m_f[5] >= 12) begin m_f[5] = 1; carry = 1; end else m_f[5] = m_f[5] + 1;
        end
      end
      if (carry == 1 && w != 6) m_f[6] = (m_f[6] >= 99) ? 0 : m_f[6] + 1;
      case (w)
        0, 1, 2, 4, 6: m_f[w] = from_bcd(int'(bus_wdata));
        3: m_f[3] = int'(bus_wdata) % 8;
        5: m_f[5] = int'(bus_wdata) % 16;
        default: ;
      endcase
    end
  end

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // compare the addressed register against the model every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(bus_rd ? tag_of(int'(bus_addr)) : "R6", int'(bus_rdata),
            bus_rd ? model_read(int'(bus_addr)) : 0, "model compare");
    end
  end

  int cyc_n = 0;
  task automatic cyc(bit t, bit w, int a, int d);
    @(negedge clk);
    #1;
    tick_1hz  = t;
    bus_wr    = w;
    bus_rd    = !w;
    bus_addr  = 3'(a);
    bus_wdata = 8'(d);
    cyc_n++;
  endtask

  task automatic expect_reg(int a, int exp, string tag);
    cyc(0, 0, a, 0);
    #1;
    check(tag, int'(bus_rdata), exp, $sformatf("offset %0d", a));
  endtask

  task automatic preset(int s, int mi, int h, int wd, int d, int mo, int y);
    cyc(0, 1, 6, y);
    cyc(0, 1, 5, mo);
    cyc(0, 1, 4, d);
    cyc(0, 1, 3, wd);
    cyc(0, 1, 2, h);
    cyc(0, 1, 1, mi);
    cyc(0, 1, 0, s);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10 reset values, R1 order, R6 status
    expect_reg(0, 8'h00, "R10");
    expect_reg(1, 8'h00, "R10");
    expect_reg(2, 8'h00, "R10");
    expect_reg(3, 8'h00, "R10");
    expect_reg(4, 8'h01, "R10");
    expect_reg(5, 8'h01, "R10");
    expect_reg(6, 8'h00, "R10");
    expect_reg(7, 8'h00, "R6");
    // R7 no tick, no change
    repeat (5) cyc(0, 0, 0, 0);
    expect_reg(0, 8'h00, "R7");
    // R7 ticks: 75 seconds -> 01:15
    for (int i = 0; i < 75; i++) cyc(1, 0, i % 8, 0);
    expect_reg(0, 8'h15, "R7");
    expect_reg(1, 8'h01, "R7");
    // R1 R2 preset and read back
    preset(8'h42, 8'h37, 8'h19, 4, 8'h27, 11, 8'h58);
    expect_reg(0, 8'h42, "R1");
    expect_reg(2, 8'h19, "R2");
    expect_reg(3, 8'h04, "R3");
    expect_reg(5, 8'h0B, "R4");
    expect_reg(6, 8'h58, "R2");
    // R5 R4 R3 full new-year rollover
    preset(8'h59, 8'h59, 8'h23, 6, 8'h31, 12, 8'h99);
    cyc(1, 0, 0, 0);
    expect_reg(0, 8'h00, "R7");
    expect_reg(2, 8'h00, "R7");
    expect_reg(3, 8'h00, "R3");
    expect_reg(4, 8'h01, "R8");
    expect_reg(5, 8'h01, "R4");
    expect_reg(6, 8'h00, "R5");
    // R8 February, non-leap year 23
    preset(8'h59, 8'h59, 8'h23, 2, 8'h28, 2, 8'h23);
    cyc(1, 0, 4, 0);
    expect_reg(4, 8'h01, "R8");
    expect_reg(5, 8'h03, "R8");
    expect_reg(3, 8'h03, "R3");
    // R8 leap year 24
    preset(8'h59, 8'h59, 8'h23, 2, 8'h28, 2, 8'h24);
    cyc(1, 0, 4, 0);
    expect_reg(4, 8'h29, "R8");
    expect_reg(5, 8'h02, "R8");
    preset(8'h59, 8'h59, 8'h23, 3, 8'h29, 2, 8'h24);
    cyc(1, 0, 4, 0);
    expect_reg(4, 8'h01, "R8");
    expect_reg(5, 8'h03, "R8");
    // R8 thirty-day month
    preset(8'h59, 8'h59, 8'h23, 0, 8'h30, 4, 8'h10);
    cyc(1, 0, 4, 0);
    expect_reg(4, 8'h01, "R8");
    expect_reg(5, 8'h05, "R8");
    // R9 write wins over tick on seconds
    preset(8'h10, 8'h20, 8'h05, 1, 8'h02, 6, 8'h30);
    cyc(1, 1, 0, 8'h30);
    expect_reg(0, 8'h30, "R9");
    // R9 displaced increment carries nothing: write 59 with tick
    cyc(1, 1, 0, 8'h59);
    expect_reg(0, 8'h59, "R9");
    expect_reg(1, 8'h20, "R9");
    // R9 minute write while seconds carry
    cyc(1, 1, 1, 8'h10);
    expect_reg(0, 8'h00, "R9");
    expect_reg(1, 8'h10, "R9");
    expect_reg(2, 8'h05, "R9");
    // R6 write to status ignored
    cyc(0, 1, 7, 8'hFF);
    expect_reg(7, 8'h00, "R6");
    expect_reg(0, 8'h00, "R6");
    expect_reg(1, 8'h10, "R6");
    expect_reg(5, 8'h06, "R6");
    // R6 idle read bus
    cyc(0, 0, 0, 0);
    bus_rd = 1'b0;
    #1 check("R6", int'(bus_rdata), 0, "rd low");
    // long run of ticks with rotating reads
    for (int i = 0; i < 4000; i++) cyc(1, 0, i % 8, 0);
    cyc(0, 0, 0, 0);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc_n);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule